// File: doc/BRIEF.md
# Cascadable Signed/Unsigned Magnitude Comparator

This block decides the order of two 8-bit words, P and Q, and reports whether P is greater than or less than Q. A mode input chooses how the words are read at run time: as plain unsigned binary, or as two's-complement signed values. The P operand goes through a level-sensitive latch. Its enable lets a caller hold one operand while a series of Q values is presented against it. Reset clears the held value to zero.

Two cascade inputs take the verdict of a less significant stage. They pass to the outputs only when the local words are equal, so stages can be chained into a comparator of any width. In a chain, the least significant stage has both cascade inputs tied low and runs in unsigned mode. Only the most significant stage uses signed mode for a signed comparison. When the chain ends with both outputs low, the full words are equal.

Top module: `mag_cmp_cascade`

## Requirements
- R1: While `rst_n` is low the held P value is cleared to zero. After `rst_n` returns high with `p_load` low, the block compares Q against 0, whatever `p_in` carries.
- R2: While `p_load` is high the latch is transparent, and the comparison follows the live `p_in`.
- R3: When `p_load` falls, the `p_in` value present at that moment is kept and used. Later changes on `p_in` have no effect on the outputs while `p_load` stays low.
- R4: With `mode_uns` = 1 both words are ordered as unsigned numbers from 0 to 255.
- R5: With `mode_uns` = 0 both words are ordered as two's-complement numbers from -128 to 127, where bit 7 is the sign bit.
- R6: If P orders above Q in the selected mode, then `gt_out` = 1 and `lt_out` = 0, whatever the cascade inputs are.
- R7: If P orders below Q in the selected mode, then `gt_out` = 0 and `lt_out` = 1, whatever the cascade inputs are.
- R8: If P equals Q, then `gt_out` copies `gt_in` and `lt_out` copies `lt_in`.
- R9: Two stages can be chained to give a correct 16-bit comparison. To do so, connect the lower stage's `gt_out`/`lt_out` to the upper stage's `gt_in`/`lt_in`, tie the lower stage's cascade inputs low and set its mode to unsigned. With both outputs low, the 16-bit words are equal.
- R10: `gt_out` and `lt_out` are never high together unless `gt_in` and `lt_in` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low clear of the held P value |
| p_load | input | 1 | Latch enable for P: 1 = transparent, 0 = hold |
| mode_uns | input | 1 | 1 = unsigned ordering, 0 = two's-complement ordering |
| p_in | input | 8 | P operand, bit 0 least significant |
| q_in | input | 8 | Q operand, bit 0 least significant |
| gt_in | input | 1 | Greater verdict from the less significant stage |
| lt_in | input | 1 | Less verdict from the less significant stage |
| gt_out | output | 1 | P greater than Q (or cascaded greater on equality) |
| lt_out | output | 1 | P less than Q (or cascaded less on equality) |

## Verification
No result of this block waits for a clock edge. The outputs follow P (through the open or held latch), Q, the mode and the cascade inputs in zero cycles, and the held value changes only on the level of `p_load` or `rst_n`. The checks therefore change the inputs and then let a fixed quarter nanosecond pass before they read the outputs. No sample ever waits for or straddles a clock edge. The full operand sweep covers both modes and all four cascade patterns. It computes the expected order with the simulator's own signed and unsigned integer comparison, not with any bit-level scheme.

// File: rtl/cmp_pkg.sv
`timescale 1ns/1ps
// Shared types for the magnitude comparator.
// Assumes: one comparison mode bit, encoded so that 1 means unsigned.
package cmp_pkg;
    typedef enum logic {
        MODE_SIGNED   = 1'b0,
        MODE_UNSIGNED = 1'b1
    } cmp_mode_e;

    // Local verdict of one stage before the cascade inputs are merged.
    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } verdict_t;
endpackage

// File: rtl/p_hold_latch.sv
`timescale 1ns/1ps
// Level-sensitive storage for the P operand.
// It is transparent while load is high and holds while load is low.
// An active-low clear forces zero and takes priority over load.
// Assumes: load settles before the data it must capture goes away.
module p_hold_latch #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clear, pass or hold the operand.
    always_latch begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/sign_bias.sv
`timescale 1ns/1ps
// Maps a word onto an unsigned scale for the selected mode.
// In signed mode the top bit is inverted, so two's-complement order becomes unsigned order.
// Assumes: the word's top bit is its sign bit in signed mode.
module sign_bias
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  cmp_mode_e    mode,
    input  logic [W-1:0] w_i,
    output logic [W-1:0] w_o
);
    localparam int MSB = W - 1;

    logic flip;
    assign flip = (mode == MODE_SIGNED);

    // Invert the sign bit only, and pass the rest through.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == MSB) begin : g_sign
            assign w_o[i] = w_i[i] ^ flip;
        end else begin : g_plain
            assign w_o[i] = w_i[i];
        end
    end
endmodule

// File: rtl/order_core.sv
`timescale 1ns/1ps
// Unsigned ordering of two words, scanned from the top bit down.
// The first bit position that differs decides the verdict.
// Assumes: the operands are already mapped to unsigned order.
module order_core
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output verdict_t     v
);
    // Find the highest differing bit and set one verdict flag.
    always_comb begin
        logic same_above;
        same_above = 1'b1;
        v = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (same_above && (a[i] != b[i])) begin
                v.gt = a[i];
                v.lt = b[i];
            end
            same_above = same_above & (a[i] == b[i]);
        end
        v.eq = same_above;

        p_one_verdict_r6: assert ($onehot({v.gt, v.lt, v.eq}))
            else $error("core verdict not one-hot");
        p_gt_order_r6: assert (v.gt == (a > b))
            else $error("core gt disagrees with unsigned order");
        p_lt_order_r7: assert (v.lt == (a < b))
            else $error("core lt disagrees with unsigned order");
    end
endmodule

// File: rtl/cascade_merge.sv
`timescale 1ns/1ps
// Merges the local verdict with the verdict of the less significant stage.
// A local decision wins, and the cascade inputs pass only on equality.
// Assumes: the local verdict is one-hot.
module cascade_merge
    import cmp_pkg::*;
(
    input  verdict_t v,
    input  logic     gt_in,
    input  logic     lt_in,
    output logic     gt_out,
    output logic     lt_out
);
    // Select the local decision or the forwarded one.
    always_comb begin
        if (v.eq) begin
            gt_out = gt_in;
            lt_out = lt_in;
        end else begin
            gt_out = v.gt;
            lt_out = v.lt;
        end

        p_eq_pass_r8: assert (!v.eq || ((gt_out == gt_in) && (lt_out == lt_in)))
            else $error("equal words did not forward cascade");
        p_excl_r10: assert ((gt_in && lt_in) || !(gt_out && lt_out))
            else $error("both outputs high without both cascade inputs");
    end
endmodule

// File: rtl/mag_cmp_cascade.sv
`timescale 1ns/1ps
// One stage of a cascadable magnitude comparator.
// The P operand is latched, both words are biased for the mode, ordered, and merged with the cascade inputs.
// Assumes: the least significant stage of a chain ties gt_in and lt_in low and uses unsigned mode.
module mag_cmp_cascade
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         p_load,
    input  logic         mode_uns,
    input  logic [W-1:0] p_in,
    input  logic [W-1:0] q_in,
    input  logic         gt_in,
    input  logic         lt_in,
    output logic         gt_out,
    output logic         lt_out
);
    cmp_mode_e    mode;
    logic [W-1:0] p_held;
    logic [W-1:0] p_biased;
    logic [W-1:0] q_biased;
    verdict_t     local_v;

    assign mode = cmp_mode_e'(mode_uns);

    p_hold_latch #(.W(W)) u_latch (
        .rst_n (rst_n),
        .load  (p_load),
        .d     (p_in),
        .q     (p_held)
    );

    sign_bias #(.W(W)) u_bias_p (
        .mode (mode),
        .w_i  (p_held),
        .w_o  (p_biased)
    );

    sign_bias #(.W(W)) u_bias_q (
        .mode (mode),
        .w_i  (q_in),
        .w_o  (q_biased)
    );

    order_core #(.W(W)) u_core (
        .a (p_biased),
        .b (q_biased),
        .v (local_v)
    );

    cascade_merge u_merge (
        .v      (local_v),
        .gt_in  (gt_in),
        .lt_in  (lt_in),
        .gt_out (gt_out),
        .lt_out (lt_out)
    );
endmodule

// File: tb/test_mag_cmp_cascade.sv
`timescale 1ns/1ps
module test_mag_cmp_cascade;
    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic       rst_n = 1'b0;
    logic       lo_load = 1'b1, lo_mode = 1'b1;
    logic [7:0] lo_p = '0, lo_q = '0;
    logic       lo_gi = 1'b0, lo_li = 1'b0;
    logic       lo_go, lo_lo;

    logic       hi_load = 1'b1, hi_mode = 1'b1;
    logic [7:0] hi_p = '0, hi_q = '0;
    logic       hi_go, hi_lo;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    mag_cmp_cascade i_mag_cmp_cascade (
        .rst_n(rst_n), .p_load(lo_load), .mode_uns(lo_mode),
        .p_in(lo_p), .q_in(lo_q), .gt_in(lo_gi), .lt_in(lo_li),
        .gt_out(lo_go), .lt_out(lo_lo)
    );

    mag_cmp_cascade i_mag_cmp_cascade_hi (
        .rst_n(rst_n), .p_load(hi_load), .mode_uns(hi_mode),
        .p_in(hi_p), .q_in(hi_q), .gt_in(lo_go), .lt_in(lo_lo),
        .gt_out(hi_go), .lt_out(hi_lo)
    );

    task automatic chk(input string req, input logic g, input logic l,
                       input logic eg, input logic el);
        checks++;
        if (g !== eg || l !== el) begin
            fails++;
            $display("FAIL %s: got gt=%0b lt=%0b expected gt=%0b lt=%0b",
                     req, g, l, eg, el);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // R1: reset clears the held P; p_in is ignored while p_load is low.
    task automatic t_reset_state();
        lo_load = 1'b0; lo_mode = 1'b1; lo_p = 8'hAB; lo_q = 8'h00;
        lo_gi = 1'b0; lo_li = 1'b0;
        rst_n = 1'b0; #1;
        rst_n = 1'b1; #0.25;
        chk("R1 held zero vs q=0", lo_go, lo_lo, 1'b0, 1'b0);
        lo_q = 8'h01; #0.25;
        chk("R1 held zero vs q=1", lo_go, lo_lo, 1'b0, 1'b1);
    endtask

    // R2: transparent latch follows p_in live.
    task automatic t_transparent();
        lo_load = 1'b1; lo_mode = 1'b1; lo_q = 8'h50;
        lo_p = 8'h60; #0.25;
        chk("R2 live p above", lo_go, lo_lo, 1'b1, 1'b0);
        lo_p = 8'h20; #0.25;
        chk("R2 live p below", lo_go, lo_lo, 1'b0, 1'b1);
    endtask

    // R3: value at the fall of p_load is held while Q and p_in move.
    task automatic t_hold();
        lo_load = 1'b1; lo_mode = 1'b1; lo_p = 8'h40; #0.25;
        lo_load = 1'b0; #0.25;
        lo_p = 8'h10; lo_q = 8'h30; #0.25;
        chk("R3 held 0x40 vs 0x30", lo_go, lo_lo, 1'b1, 1'b0);
        lo_p = 8'hFF; lo_q = 8'h41; #0.25;
        chk("R3 held 0x40 vs 0x41", lo_go, lo_lo, 1'b0, 1'b1);
        lo_q = 8'h40; #0.25;
        chk("R3 held 0x40 vs 0x40", lo_go, lo_lo, 1'b0, 1'b0);
        lo_load = 1'b1; #0.25;
    endtask

    // R4 R5 R6 R7 R8 R10: full operand sweep, both modes, all cascade inputs.
    task automatic t_sweep();
        lo_load = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                for (int p = 0; p < 256; p++) begin
                    for (int q = 0; q < 256; q++) begin
                        logic eg, el;
                        lo_mode = m[0]; lo_gi = c[1]; lo_li = c[0];
                        lo_p = p[7:0]; lo_q = q[7:0];
                        if (m == 1) begin
                            eg = (p > q); el = (p < q);
                        end else begin
                            eg = ($signed(p[7:0]) > $signed(q[7:0]));
                            el = ($signed(p[7:0]) < $signed(q[7:0]));
                        end
                        if (p == q) begin
                            eg = c[1]; el = c[0];
                        end
                        #0.25;
                        if (m == 1)
                            chk("R4 R6 R7 R8 R10 unsigned", lo_go, lo_lo, eg, el);
                        else
                            chk("R5 R6 R7 R8 R10 signed", lo_go, lo_lo, eg, el);
                    end
                end
            end
        end
        lo_gi = 1'b0; lo_li = 1'b0; lo_mode = 1'b1;
    endtask

    // R9: two stages form a 16-bit comparator.
    task automatic chain_one(input logic [15:0] a, input logic [15:0] b, input logic sgn);
        logic eg, el;
        lo_mode = 1'b1; lo_gi = 1'b0; lo_li = 1'b0; hi_mode = ~sgn;
        lo_p = a[7:0]; hi_p = a[15:8]; lo_q = b[7:0]; hi_q = b[15:8];
        if (sgn) begin
            eg = ($signed(a) > $signed(b)); el = ($signed(a) < $signed(b));
        end else begin
            eg = (a > b); el = (a < b);
        end
        #0.25;
        chk("R9 16-bit chain", hi_go, hi_lo, eg, el);
    endtask

    task automatic t_chain();
        lo_load = 1'b1; hi_load = 1'b1;
        chain_one(16'h1234, 16'h1234, 1'b0);
        chain_one(16'h1235, 16'h1234, 1'b0);
        chain_one(16'h12FF, 16'h1300, 1'b0);
        chain_one(16'h8000, 16'h7FFF, 1'b0);
        chain_one(16'h8000, 16'h7FFF, 1'b1);
        chain_one(16'hFFFF, 16'h0000, 1'b1);
        chain_one(16'hFF01, 16'hFF80, 1'b1);
        chain_one(16'h7F80, 16'h7F7F, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got cycles=%0d expected fewer", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_transparent();
        t_hold();
        t_sweep();
        t_chain();
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end
endmodule